// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block lends the external bus from the CPU to an outside master and takes it back. The outside master asks for the bus by pulling an active-low hold line. The block registers that line on each falling phase of the system clock and turns it into an internal request. It grants the request only on a rising phase, and only when the bus-request sampling window is open and no memory-refresh request is pending.

A grant runs in two steps, each one phase-clock cycle apart. First the CPU clock is stopped low and the two status pins show the hold code. One cycle later the bus and its direction and byte-enable pins float. Release takes the same two steps in reverse: the status pins return first, and the bus is driven again and the CPU clock restarts one cycle after that. For the whole hold the watchdog is stopped, the port pins are frozen, the enable strobe is forced high and the address-latch strobe is forced low.

The design runs on one fast clock. The system phase clock is modelled by a run flag and by two one-cycle strobes that mark its rising and falling phases. When the run flag is low, nothing in the block changes.

Top module: `bhold_ctrl`

## Requirements
- R1: The internal request takes the inverse of `hold_n` at a clock edge where `phi_run` and `ph_fall` are both 1. At every other edge it keeps its value.
- R2: A grant leaves idle only at an edge where `phi_run` and `ph_rise` are 1, the request is 1, `samp_win` is 1 and `rfsh_req` is 0. A pending refresh request or a closed window keeps the block idle.
- R3: At the grant edge, `st0_o` goes to 1, `st1_o` goes to 0 and `cpu_clk_en_o` goes to 0. In normal run the status pins are `st0_o`=0 and `st1_o`=1, and `cpu_clk_en_o`=1.
- R4: `bus_float_o` goes to 1 at the first rising-phase edge after the status change, which is one phase cycle later.
- R5: While floated, a rising-phase edge with the request at 0 returns the status pins to their run values. At the next rising-phase edge `bus_float_o` falls and `cpu_clk_en_o` returns to 1.
- R6: `wdt_stop_o` and `port_freeze_o` are 1 from the grant edge until the edge that ends the release, and 0 otherwise.
- R7: During hold, `e_o` is 1 and `ale_o` is 0. Outside hold they follow `cpu_e` and `cpu_ale`.
- R8: A request withdrawn before a grant starts no sequence. Once a grant has occurred, the float step completes whatever the request does.
- R9: While `phi_run` is 0, neither the request nor the sequence state changes.
- R10: After reset the block is idle: `st0_o`=0, `st1_o`=1, `bus_float_o`=0, `cpu_clk_en_o`=1, `wdt_stop_o`=0 and `port_freeze_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi_run | input | 1 | Phase clock running (0 = stopped for a ready wait or a stop/wait state) |
| ph_rise | input | 1 | One-cycle strobe marking the rising phase |
| ph_fall | input | 1 | One-cycle strobe marking the falling phase |
| hold_n | input | 1 | Active-low bus hold request from the outside master |
| samp_win | input | 1 | Bus-request sampling window |
| rfsh_req | input | 1 | Memory-refresh bus request, which takes priority over hold |
| cpu_e | input | 1 | Enable strobe level from the CPU |
| cpu_ale | input | 1 | Address-latch strobe level from the CPU |
| cpu_clk_en_o | output | 1 | CPU clock gate (0 = CPU clock held low) |
| st0_o | output | 1 | Status pin 0 |
| st1_o | output | 1 | Status pin 1 |
| e_o | output | 1 | Enable strobe level to the pad |
| ale_o | output | 1 | Address-latch strobe level to the pad |
| bus_float_o | output | 1 | Float enable for the bus, direction and byte-enable pins |
| wdt_stop_o | output | 1 | Watchdog stop |
| port_freeze_o | output | 1 | Port pins keep the state they had at the grant |

## Verification
The assertions assume that `ph_rise` and `ph_fall` are never high in the same cycle, and that neither strobe matters while `phi_run` is 0. The bench meets this by deriving both strobes from one phase counter that advances only while the phase clock runs. That counter places a rising phase every four fast cycles and a falling phase two cycles after each rising phase. The random hold line, window, refresh request and run flag change only between clock edges, so every input respects the strobe pattern at each edge.

// File: rtl/bhold_pkg.sv
package bhold_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_STATUS  = 2'd1,
    HS_FLOATED = 2'd2,
    HS_RELEASE = 2'd3
  } hold_state_e;
endpackage

// File: rtl/bhold_rst_sync.sv
module bhold_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bhold_sampler.sv
module bhold_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_run,
  input  logic ph_fall,
  input  logic hold_n,
  output logic hold_req
);
  logic req_q, req_d, samp_en;

  assign samp_en = phi_run & ph_fall;

  always_comb begin
    req_d = req_q;
    if (samp_en) req_d = ~hold_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign hold_req = req_q;

  // R1: request follows the inverted pin at a falling phase
  a_r1_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (phi_run && ph_fall) |=> (hold_req == !$past(hold_n)));
  // R9: request frozen whenever no running falling phase
  a_r9_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi_run && ph_fall) |=> $stable(hold_req));
endmodule

// File: rtl/bhold_fsm.sv
module bhold_fsm
  import bhold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phi_run,
  input  logic        ph_rise,
  input  logic        hold_req,
  input  logic        samp_win,
  input  logic        rfsh_req,
  output hold_state_e state
);
  hold_state_e st_q, st_d;
  logic step, grant;

  assign step  = phi_run & ph_rise;
  assign grant = step & hold_req & samp_win & ~rfsh_req;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE:    if (grant)             st_d = HS_STATUS;
      HS_STATUS:  if (step)              st_d = HS_FLOATED;
      HS_FLOATED: if (step && !hold_req) st_d = HS_RELEASE;
      HS_RELEASE: if (step)              st_d = HS_IDLE;
      default:                           st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R2: leaving idle needs window open and no refresh
  a_r2_accept_rules: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_STATUS && $past(st_q) == HS_IDLE) |->
      $past(samp_win && !rfsh_req && hold_req && ph_rise));
  // R8: after grant the float step always follows
  a_r8_entry_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_STATUS) |=> (st_q == HS_STATUS || st_q == HS_FLOATED));
  // R9: sequence frozen while phase clock stopped
  a_r9_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !phi_run |=> $stable(st_q));
endmodule

// File: rtl/bhold_drive.sv
module bhold_drive
  import bhold_pkg::*;
#(
  parameter bit ST0_RUN  = 1'b0,
  parameter bit ST1_RUN  = 1'b1,
  parameter bit ST0_HOLD = 1'b1,
  parameter bit ST1_HOLD = 1'b0
) (
  input  hold_state_e state,
  input  logic        cpu_e,
  input  logic        cpu_ale,
  output logic        cpu_clk_en_o,
  output logic        st0_o,
  output logic        st1_o,
  output logic        e_o,
  output logic        ale_o,
  output logic        bus_float_o,
  output logic        wdt_stop_o,
  output logic        port_freeze_o
);
  logic in_hold, stat_hold;

  always_comb begin
    in_hold   = (state != HS_IDLE);
    stat_hold = (state == HS_STATUS) || (state == HS_FLOATED);
    st0_o         = stat_hold ? ST0_HOLD : ST0_RUN;
    st1_o         = stat_hold ? ST1_HOLD : ST1_RUN;
    bus_float_o   = (state == HS_FLOATED) || (state == HS_RELEASE);
    cpu_clk_en_o  = ~in_hold;
    wdt_stop_o    = in_hold;
    port_freeze_o = in_hold;
    e_o           = in_hold ? 1'b1 : cpu_e;
    ale_o         = in_hold ? 1'b0 : cpu_ale;
  end
endmodule

// File: rtl/bhold_ctrl.sv
module bhold_ctrl
  import bhold_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_run,
  input  logic ph_rise,
  input  logic ph_fall,
  input  logic hold_n,
  input  logic samp_win,
  input  logic rfsh_req,
  input  logic cpu_e,
  input  logic cpu_ale,
  output logic cpu_clk_en_o,
  output logic st0_o,
  output logic st1_o,
  output logic e_o,
  output logic ale_o,
  output logic bus_float_o,
  output logic wdt_stop_o,
  output logic port_freeze_o
);
  logic        rst_n_i;
  logic        hold_req;
  hold_state_e state;

  bhold_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  bhold_sampler u_samp (
    .clk(clk), .rst_n(rst_n_i), .phi_run(phi_run), .ph_fall(ph_fall),
    .hold_n(hold_n), .hold_req(hold_req)
  );

  bhold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i), .phi_run(phi_run), .ph_rise(ph_rise),
    .hold_req(hold_req), .samp_win(samp_win), .rfsh_req(rfsh_req),
    .state(state)
  );

  bhold_drive u_drv (
    .state(state), .cpu_e(cpu_e), .cpu_ale(cpu_ale),
    .cpu_clk_en_o(cpu_clk_en_o), .st0_o(st0_o), .st1_o(st1_o),
    .e_o(e_o), .ale_o(ale_o), .bus_float_o(bus_float_o),
    .wdt_stop_o(wdt_stop_o), .port_freeze_o(port_freeze_o)
  );

  // R3: status change coincides with the CPU clock stopping
  a_r3_clock_stops: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(st0_o) |-> !cpu_clk_en_o);
  // R4: float only starts after the status pins already show hold
  a_r4_float_after_status: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(bus_float_o) |-> ($past(st0_o) && st0_o));
  // R5: float ends only after the status pins went back
  a_r5_release_order: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(bus_float_o) |-> !$past(st0_o));
  // R7: strobes pinned while floated
  a_r7_strobes_pinned: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_float_o |-> (e_o && !ale_o && !cpu_clk_en_o));
endmodule

// File: tb/test_bhold_ctrl.sv
`timescale 1ns/1ps
module test_bhold_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic phi_run = 1'b1, ph_rise = 1'b0, ph_fall = 1'b0;
  logic hold_n = 1'b1, samp_win = 1'b1, rfsh_req = 1'b0;
  logic cpu_e = 1'b0, cpu_ale = 1'b0;
  logic cpu_clk_en_o, st0_o, st1_o, e_o, ale_o, bus_float_o, wdt_stop_o, port_freeze_o;

  int checks = 0, failures = 0;
  int phase_cnt = 0;
  int m_state = 0;
  logic m_req = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  bhold_ctrl i_bhold_ctrl (
    .clk(clk), .rst_n(rst_n), .phi_run(phi_run), .ph_rise(ph_rise), .ph_fall(ph_fall),
    .hold_n(hold_n), .samp_win(samp_win), .rfsh_req(rfsh_req),
    .cpu_e(cpu_e), .cpu_ale(cpu_ale), .cpu_clk_en_o(cpu_clk_en_o),
    .st0_o(st0_o), .st1_o(st1_o), .e_o(e_o), .ale_o(ale_o),
    .bus_float_o(bus_float_o), .wdt_stop_o(wdt_stop_o), .port_freeze_o(port_freeze_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected state after one edge: 0 idle, 1 status, 2 floated, 3 release
  function automatic int next_state(input int s, input bit req, input bit run,
                                    input bit rise, input bit win, input bit rf);
    bit step = run && rise;
    case (s)
      0: return (step && req && win && !rf) ? 1 : 0;
      1: return step ? 2 : 1;
      2: return (step && !req) ? 3 : 2;
      default: return step ? 0 : 3;
    endcase
  endfunction

  task automatic compare_model();
    bit hold = (m_state != 0);
    bit stat = (m_state == 1) || (m_state == 2);
    bit flt  = (m_state == 2) || (m_state == 3);
    chk(st0_o == stat,  "R3 st0", st0_o, stat);
    chk(st1_o == !stat, "R3 st1", st1_o, !stat);
    chk(cpu_clk_en_o == !hold, "R5 cpu_clk_en", cpu_clk_en_o, !hold);
    chk(bus_float_o == flt, "R4 bus_float", bus_float_o, flt);
    chk(wdt_stop_o == hold && port_freeze_o == hold, "R6 wdt/port",
        {wdt_stop_o, port_freeze_o}, {hold, hold});
    chk(e_o == (hold ? 1'b1 : cpu_e) && ale_o == (hold ? 1'b0 : cpu_ale), "R7 e/ale",
        {e_o, ale_o}, hold ? 2 : {cpu_e, cpu_ale});
  endtask

  task automatic tick();
    int ns;
    @(negedge clk);
    ph_rise = phi_run && (phase_cnt % 4 == 0);
    ph_fall = phi_run && (phase_cnt % 4 == 2);
    if (phi_run) phase_cnt++;
    @(posedge clk);
    #1;
    if (model_on) begin
      ns = next_state(m_state, m_req, phi_run, ph_rise, samp_win, rfsh_req);
      if (phi_run && ph_fall) m_req = !hold_n;
      m_state = ns;
      compare_model();
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    ticks(3);
    @(negedge clk); rst_n = 1'b1;
    ticks(5);
    // R10: reset state
    chk(st0_o == 0 && st1_o == 1, "R10 status", {st0_o, st1_o}, 1);
    chk(bus_float_o == 0 && cpu_clk_en_o == 1, "R10 float/clk", {bus_float_o, cpu_clk_en_o}, 1);
    chk(wdt_stop_o == 0 && port_freeze_o == 0, "R10 wdt/port", {wdt_stop_o, port_freeze_o}, 0);
    model_on = 1'b1;

    // R2: refresh pending blocks acceptance
    rfsh_req = 1; hold_n = 0; ticks(24);
    chk(st0_o == 0 && wdt_stop_o == 0, "R2 refresh blocks", st0_o, 0);
    // R2: closed window blocks acceptance
    rfsh_req = 0; samp_win = 0; ticks(24);
    chk(st0_o == 0, "R2 window blocks", st0_o, 0);
    // R8: request withdrawn before grant
    hold_n = 1; ticks(8); samp_win = 1; ticks(16);
    chk(st0_o == 0 && bus_float_o == 0, "R8 withdrawn", st0_o, 0);

    // R4: status to float spacing of one phase cycle (4 fast cycles)
    hold_n = 0;
    n = 0; while (!st0_o && n < 40) begin tick(); n++; end
    chk(st0_o == 1 && cpu_clk_en_o == 0, "R3 grant", st0_o, 1);
    n = 0; while (!bus_float_o && n < 40) begin tick(); n++; end
    chk(n == 4, "R4 status->float cycles", n, 4);
    ticks(8);
    // R5: release spacing
    hold_n = 1;
    n = 0; while (st0_o && n < 40) begin tick(); n++; end
    chk(st0_o == 0 && bus_float_o == 1, "R5 status first", {st0_o, bus_float_o}, 1);
    n = 0; while (bus_float_o && n < 40) begin tick(); n++; end
    chk(n == 4 && cpu_clk_en_o == 1, "R5 status->unfloat cycles", n, 4);

    // R8: request dropped right after grant still floats
    ticks(8); hold_n = 0;
    n = 0; while (!st0_o && n < 40) begin tick(); n++; end
    hold_n = 1;
    n = 0; while (!bus_float_o && n < 40) begin tick(); n++; end
    chk(bus_float_o == 1 && n == 4, "R8 entry completes", n, 4);
    ticks(16);
    chk(bus_float_o == 0, "R8 then released", bus_float_o, 0);

    // R9: stopped phase clock freezes everything
    hold_n = 0; ticks(12);
    phi_run = 0; hold_n = 1; ticks(20);
    chk(bus_float_o == 1 && st0_o == 1, "R9 frozen in hold", {bus_float_o, st0_o}, 3);
    phi_run = 1; ticks(20);
    chk(bus_float_o == 0, "R9 resumes release", bus_float_o, 0);

    // R1 R7: random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(19) == 0) hold_n = ~hold_n;
      samp_win = ($urandom_range(3) != 0);
      rfsh_req = ($urandom_range(7) == 0);
      phi_run  = ($urandom_range(15) != 0);
      cpu_e    = $urandom_range(1);
      cpu_ale  = $urandom_range(1);
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule